// File: doc/BRIEF.md
# Single-Buffer Serial Port with Register Bus

This block is a serial port peripheral for an on-chip register bus. Software writes a byte to the data register, the block holds it in a one-byte transmit buffer and sends it as a fixed 8N1 frame. Incoming frames are sampled from the receive pin and kept in a one-byte receive buffer until software reads the data register. There are no FIFOs, no parity, no modem lines and no flow control.

The bit time is set by a 21-bit divider register that holds the number of clock cycles per serial bit. The lowest usable setting is 16. Transmit-buffer drain, byte arrival and the two overrun conditions each latch a sticky interrupt bit. Software clears such a bit by writing a 1 to it. Each sticky bit is gated by its own enable. The block drives one interrupt line for transmit, one for receive, one for both overruns, and one combined line.

The bus has no wait states. A write takes effect on the clock edge where select and write are both high. Read data is combinational while select is high and write is low. A read of the data register consumes the received byte on that same edge.

The transmit holding buffer feeds the shifter over a valid/ready handshake inside the block. The buffer asserts valid while it is full. The shifter asserts ready while it is idle and transmit is enabled. When valid and ready are high on the same edge, the byte moves into the shifter. The receive side has no back-pressure: if the buffer is still full when a byte completes, the new byte is dropped and an overrun is flagged.

Top module: `sbu_uart`

## Requirements
- R1: After reset, STATE, CTRL and INT read 0, the divider reads 16, the TX pin is high and all four interrupt lines are low.
- R2: A write to DATA (word offset 0x00) while TX is not full stores the byte and sets STATE bit 0. A write while it is full sets STATE bit 2 and INT bit 2, and the byte is never transmitted.
- R3: When CTRL bit 0 is set, a held byte goes out as a low start bit, eight data bits LSB first and a high stop bit, each lasting divider clock cycles. When CTRL bit 0 is clear, the byte stays held and the pin stays high.
- R4: When the held byte moves into the shifter, STATE bit 0 clears and INT bit 0 sets.
- R5: The RX pin passes through a two-flop synchronizer. A low level is accepted as a start bit only if it is still low half a bit time later, so a shorter pulse yields no byte. Data bits are sampled at mid-bit, LSB first. A completed frame with a high stop bit sets STATE bit 1 and INT bit 1. Nothing is received while CTRL bit 1 is clear.
- R6: A read of DATA returns the received byte and clears STATE bit 1.
- R7: When a byte completes while RX is full, STATE bit 3 and INT bit 3 set and the old byte is kept. If a DATA read falls on the completion cycle, the new byte is stored and no overrun is flagged.
- R8: Writing 1 to an INT bit (offset 0x0C) clears it and writing 0 leaves it unchanged. STATE bits 3:2 (offset 0x04) are cleared the same way.
- R9: irq_tx = INT0 & CTRL2, irq_rx = INT1 & CTRL3, irq_ovr = (INT2 & CTRL4) | (INT3 & CTRL5). irq_any is the OR of all four enabled bits. CTRL is at offset 0x08.
- R10: The divider register (offset 0x10) keeps the low 21 bits of a write. Frames in both directions follow the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ser_rxd | input | 1 | Serial receive pin |
| ser_txd | output | 1 | Serial transmit pin |
| irq_tx | output | 1 | Transmit buffer drained, enabled |
| irq_rx | output | 1 | Byte received, enabled |
| irq_ovr | output | 1 | Either overrun, enabled |
| irq_any | output | 1 | OR of all enabled interrupts |

## Verification
The critical collision is a DATA read landing on the same edge that a new frame completes into a full receive buffer. The bench fills the buffer and starts a second frame. From the divider it computes the completion edge: two synchronizer stages, plus half a bit, plus nine bit times. It issues the read exactly on that edge, and on a later run one cycle after it. On the matching edge it expects the old byte returned, the buffer full with the new byte and no overrun. One cycle late it expects an overrun flag and an empty buffer.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int BUS_W = 32;
  localparam int FRAME_BITS = 10;
  localparam int NUM_IRQ = 4;

  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_CTRL = 3'd2;
  localparam logic [2:0] REG_INT  = 3'd3;
  localparam logic [2:0] REG_DIV  = 3'd4;

  localparam int CTL_TX_EN = 0;
  localparam int CTL_RX_EN = 1;
  localparam int CTL_IE_LO = 2;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_t;
endpackage

// File: rtl/sbu_tx.sv
module sbu_tx
  import sbu_pkg::*;
#(
  parameter int DIV_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             txd
);
  localparam int NB_W = $clog2(FRAME_BITS + 1);

  logic                  busy;
  logic [DIV_W-1:0]      cnt;
  logic [NB_W-1:0]       nbit;
  logic [FRAME_BITS-1:0] sh;

  assign in_ready = en && !busy;
  assign txd      = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '1;
    end else if (!busy) begin
      if (in_valid && in_ready) begin
        busy <= 1'b1;
        sh   <= {1'b1, in_data, 1'b0};
        cnt  <= '0;
        nbit <= '0;
      end
    end else if (cnt == div - 1'b1) begin
      cnt  <= '0;
      sh   <= {1'b1, sh[FRAME_BITS-1:1]};
      nbit <= nbit + 1'b1;
      if (nbit == NB_W'(FRAME_BITS - 1)) busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a handshake puts the start bit on the pin on the next cycle
  p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !txd);
endmodule

// File: rtl/sbu_rx.sv
module sbu_rx
  import sbu_pkg::*;
#(
  parameter int DIV_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             en,
  input  logic             rxd,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  logic             s1, s2;
  rx_state_t        st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       nbit;
  logic [7:0]       sh;
  logic [DIV_W-1:0] half;

  assign half      = div >> 1;
  assign out_data  = sh;
  assign out_valid = en && (st == RX_STOP) && (cnt == div - 1'b1) && s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
    end else if (!en) begin
      st  <= RX_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        RX_IDLE: if (!s2) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (cnt == half - 1'b1) begin
          cnt  <= '0;
          nbit <= '0;
          st   <= s2 ? RX_IDLE : RX_DATA;
        end else cnt <= cnt + 1'b1;
        RX_DATA: if (cnt == div - 1'b1) begin
          cnt  <= '0;
          sh   <= {s2, sh[7:1]};
          nbit <= nbit + 1'b1;
          if (nbit == 3'd7) st <= RX_STOP;
        end else cnt <= cnt + 1'b1;
        RX_STOP: if (cnt == div - 1'b1) begin
          cnt <= '0;
          st  <= RX_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R5: each completed frame yields a single-cycle byte strobe
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/sbu_regs.sv
module sbu_regs
  import sbu_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DIV_W   = 21,
  parameter int unsigned DIV_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_en,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_en,
  output logic [DIV_W-1:0]  div,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              irq_any
);
  localparam int CTRL_W = CTL_IE_LO + NUM_IRQ;

  logic [2:0]         idx;
  logic               in_map, wr_en, rd_en;
  logic               wr_data_reg, rd_data_reg;
  logic               tx_full, rx_full;
  logic [7:0]         tx_buf, rx_buf;
  logic [1:0]         st_ovr;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_IRQ-1:0] int_q, ev, clr, pend;
  logic               tx_take, tx_accept, tx_ovr_ev, rx_store, rx_ovr_ev;
  logic               unused_bits;

  assign idx         = bus_addr[4:2];
  assign in_map      = (bus_addr[ADDR_W-1:5] == '0) && (idx <= REG_DIV);
  assign wr_en       = bus_sel && bus_wr && in_map;
  assign rd_en       = bus_sel && !bus_wr && in_map;
  assign wr_data_reg = wr_en && (idx == REG_DATA);
  assign rd_data_reg = rd_en && (idx == REG_DATA);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:DIV_W]};

  // TX holding buffer: the write is accepted if the buffer empties this cycle
  assign tx_take   = tx_full && tx_ready;
  assign tx_accept = wr_data_reg && (!tx_full || tx_take);
  assign tx_ovr_ev = wr_data_reg && tx_full && !tx_take;
  // RX buffer: a read in the completion cycle makes room for the new byte
  assign rx_store  = rx_valid && (!rx_full || rd_data_reg);
  assign rx_ovr_ev = rx_valid && rx_full && !rd_data_reg;

  assign tx_valid = tx_full;
  assign tx_data  = tx_buf;
  assign tx_en    = ctrl_q[CTL_TX_EN];
  assign rx_en    = ctrl_q[CTL_RX_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
      rx_full <= 1'b0;
      rx_buf  <= '0;
      ctrl_q  <= '0;
      div     <= DIV_W'(DIV_RST);
    end else begin
      if (tx_accept) begin
        tx_full <= 1'b1;
        tx_buf  <= bus_wdata[7:0];
      end else if (tx_take) begin
        tx_full <= 1'b0;
      end
      if (rx_store) begin
        rx_full <= 1'b1;
        rx_buf  <= rx_data;
      end else if (rd_data_reg) begin
        rx_full <= 1'b0;
      end
      if (wr_en && idx == REG_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_en && idx == REG_DIV)  div    <= bus_wdata[DIV_W-1:0];
    end
  end

  // Sticky overrun flags in STATE, cleared by writing 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_ovr <= '0;
    else st_ovr <= (st_ovr & ~((wr_en && idx == REG_STAT) ? bus_wdata[3:2] : 2'b00))
                   | {rx_ovr_ev, tx_ovr_ev};
  end

  // Interrupt bits: bit order tx, rx, tx overrun, rx overrun
  assign ev  = {rx_ovr_ev, tx_ovr_ev, rx_store, tx_take};
  assign clr = (wr_en && idx == REG_INT) ? bus_wdata[NUM_IRQ-1:0] : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      int_q[g] <= 1'b0;
      else if (ev[g])  int_q[g] <= 1'b1;
      else if (clr[g]) int_q[g] <= 1'b0;
    end
    assign pend[g] = int_q[g] && ctrl_q[CTL_IE_LO + g];
  end

  assign irq_tx  = pend[0];
  assign irq_rx  = pend[1];
  assign irq_ovr = pend[2] || pend[3];
  assign irq_any = |pend;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (idx)
        REG_DATA: bus_rdata[7:0]        = rx_buf;
        REG_STAT: bus_rdata[3:0]        = {st_ovr, rx_full, tx_full};
        REG_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
        REG_INT:  bus_rdata[NUM_IRQ-1:0] = int_q;
        REG_DIV:  bus_rdata[DIV_W-1:0]  = div;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2: a write into a full holding buffer flags overrun and keeps the old byte
  p_tx_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_reg && tx_full && !tx_ready) |=> (st_ovr[0] && int_q[2] && $stable(tx_buf)));
  // R4: the handoff to the shifter empties the buffer and raises the tx bit
  p_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_ready && !wr_data_reg) |=> (!tx_full && int_q[0]));
  // R7: a byte arriving into a full buffer is dropped and flagged
  p_rx_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rd_data_reg) |=> (st_ovr[1] && $stable(rx_buf)));
  // R8: write-one clears the rx interrupt bit when no new byte lands
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == REG_INT && bus_wdata[1] && !rx_valid) |=> !int_q[1]);
endmodule

// File: rtl/sbu_uart.sv
module sbu_uart
  import sbu_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DIV_W   = 21,
  parameter int unsigned DIV_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ser_rxd,
  output logic              ser_txd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr,
  output logic              irq_any
);
  logic             tx_valid, tx_ready, tx_en, rx_valid, rx_en;
  logic [7:0]       tx_data, rx_data;
  logic [DIV_W-1:0] div;

  sbu_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_en(tx_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_en(rx_en), .div(div),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr), .irq_any(irq_any)
  );

  sbu_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div), .en(tx_en),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data), .txd(ser_txd)
  );

  sbu_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div), .en(rx_en), .rxd(ser_rxd),
    .out_valid(rx_valid), .out_data(rx_data)
  );
endmodule

// File: tb/sim_sbu_uart.sv
`timescale 1ns/1ps
module sim_sbu_uart;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_rxd = 1'b1;
  logic        ser_txd, irq_tx, irq_rx, irq_ovr, irq_any;

  int n_chk = 0, n_bad = 0;
  int div_now = 16;
  logic [7:0] tx_exp[$];
  logic [7:0] m_got, m_exp;
  logic       m_ok;
  logic [31:0] v;

  localparam logic [11:0] A_DATA = 12'h000, A_STAT = 12'h004, A_CTRL = 12'h008,
                          A_INT = 12'h00C, A_DIV = 12'h010;

  always #5 clk = ~clk;

  sbu_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_rxd(ser_rxd), .ser_txd(ser_txd), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_ovr(irq_ovr), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Driver: write the byte and push what the line must carry
  task automatic tx_send(input logic [7:0] b);
    bus_write(A_DATA, {24'h0, b});
    tx_exp.push_back(b);
  endtask

  task automatic wait_tx_idle();
    while (tx_exp.size() != 0) @(negedge clk);
    repeat (div_now) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] b);
    @(negedge clk); ser_rxd = 1'b0;
    repeat (div_now) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rxd = b[i];
      repeat (div_now) @(negedge clk);
    end
    ser_rxd = 1'b1;
    repeat (div_now) @(negedge clk);
  endtask

  // Monitor: decode each frame at mid-bit and compare with the queue (R3)
  initial begin
    forever begin
      @(negedge ser_txd);
      repeat (div_now / 2) @(negedge clk);
      m_ok = (ser_txd == 1'b0);
      for (int i = 0; i < 8; i++) begin
        repeat (div_now) @(negedge clk);
        m_got[i] = ser_txd;
      end
      repeat (div_now) @(negedge clk);
      m_ok = m_ok && (ser_txd == 1'b1);
      n_chk++;
      if (tx_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R3 unexpected frame act=%h exp=none", m_got);
      end else begin
        m_exp = tx_exp.pop_front();
        if (!m_ok || m_got !== m_exp) begin
          n_bad++;
          $display("FAIL R3 frame act=%h framing_ok=%0b exp=%h", m_got, m_ok, m_exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    bus_read(A_STAT, v); chk("R1 state", v, 32'h0);
    bus_read(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    bus_read(A_INT, v);  chk("R1 int", v, 32'h0);
    bus_read(A_DIV, v);  chk("R1 div", v, 32'd16);
    chk("R1 txd", {31'h0, ser_txd}, 32'h1);
    chk("R1 irq", {28'h0, irq_tx, irq_rx, irq_ovr, irq_any}, 32'h0);

    // R4 handoff, R8 write-one-clear, R9 gating
    bus_write(A_CTRL, 32'h3F);
    tx_send(8'hA5);
    bus_read(A_STAT, v); chk("R4 full cleared", v & 32'h1, 32'h0);
    bus_read(A_INT, v);  chk("R4 int tx set", v & 32'h1, 32'h1);
    chk("R9 irq_tx", {31'h0, irq_tx}, 32'h1);
    bus_write(A_INT, 32'h0);
    bus_read(A_INT, v);  chk("R8 zero keeps", v & 32'h1, 32'h1);
    bus_write(A_INT, 32'h1);
    bus_read(A_INT, v);  chk("R8 one clears", v & 32'h1, 32'h0);
    chk("R9 irq_any low", {31'h0, irq_any}, 32'h0);
    wait_tx_idle();

    // R2 tx overrun, discarded byte (monitor sees only two frames)
    tx_send(8'h3C);
    tx_send(8'h11);
    bus_write(A_DATA, 32'h22);
    bus_read(A_STAT, v); chk("R2 state full+ovr", v, 32'h5);
    bus_read(A_INT, v);  chk("R2 int ovr", v & 32'h4, 32'h4);
    chk("R9 irq_ovr on", {31'h0, irq_ovr}, 32'h1);
    bus_write(A_CTRL, 32'h2F);
    chk("R9 irq_ovr masked", {31'h0, irq_ovr}, 32'h0);
    bus_write(A_CTRL, 32'h3F);
    bus_write(A_STAT, 32'h4);
    bus_write(A_INT, 32'h4);
    bus_read(A_STAT, v); chk("R8 state ovr cleared", v & 32'h4, 32'h0);
    wait_tx_idle();

    // R3 transmit disabled holds the byte
    bus_write(A_CTRL, 32'h3E);
    tx_send(8'h77);
    repeat (40) @(negedge clk);
    bus_read(A_STAT, v); chk("R3 held while disabled", v & 32'h1, 32'h1);
    chk("R3 line idle", {31'h0, ser_txd}, 32'h1);
    bus_write(A_CTRL, 32'h3F);
    wait_tx_idle();

    // R5 / R6 receive
    bus_write(A_INT, 32'hF);
    rx_frame(8'h5A);
    bus_read(A_STAT, v); chk("R5 rx full", v, 32'h2);
    bus_read(A_INT, v);  chk("R5 int rx", v & 32'h2, 32'h2);
    chk("R9 irq_rx", {31'h0, irq_rx}, 32'h1);
    bus_read(A_DATA, v); chk("R6 data", v, 32'h5A);
    bus_read(A_STAT, v); chk("R6 consumed", v & 32'h2, 32'h0);

    // R7 rx overrun keeps old byte
    rx_frame(8'h11);
    rx_frame(8'h22);
    bus_read(A_STAT, v); chk("R7 state", v, 32'hA);
    bus_read(A_INT, v);  chk("R7 int", v & 32'h8, 32'h8);
    bus_read(A_DATA, v); chk("R7 old kept", v, 32'h11);
    bus_write(A_STAT, 32'hC);
    bus_write(A_INT, 32'hF);

    // R7 collision: read on the completion edge, then one edge late
    last = 2 + div_now / 2 + 9 * div_now;
    for (int k = 0; k < 2; k++) begin
      rx_frame(8'h33);
      fork
        rx_frame(8'h44);
        begin
          @(negedge clk);
          repeat (last + k) @(negedge clk);
          bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DATA;
          #1 v = bus_rdata;
          @(negedge clk);
          bus_sel = 1'b0;
        end
      join
      chk("R7 collision old byte", v, 32'h33);
      bus_read(A_STAT, v);
      if (k == 0) begin
        chk("R7 same edge no ovr", v, 32'h2);
        bus_read(A_DATA, v); chk("R7 same edge new byte", v, 32'h44);
      end else begin
        chk("R7 late edge ovr", v, 32'h8);
        bus_write(A_STAT, 32'hC);
      end
      bus_write(A_INT, 32'hF);
    end

    // R5 short glitch is rejected
    @(negedge clk); ser_rxd = 1'b0;
    repeat (div_now / 4) @(negedge clk);
    ser_rxd = 1'b1;
    repeat (3 * div_now) @(negedge clk);
    bus_read(A_STAT, v); chk("R5 glitch ignored", v & 32'h2, 32'h0);

    // R5 receive disabled
    bus_write(A_CTRL, 32'h3D);
    rx_frame(8'h66);
    bus_read(A_STAT, v); chk("R5 rx disabled", v & 32'h2, 32'h0);
    bus_write(A_CTRL, 32'h3F);

    // R10 divider width and new bit time
    bus_write(A_DIV, 32'hFFFF_FFFF);
    bus_read(A_DIV, v); chk("R10 div mask", v, 32'h1F_FFFF);
    bus_write(A_DIV, 32'd32);
    div_now = 32;
    tx_send(8'hC3);
    wait_tx_idle();
    rx_frame(8'h9C);
    bus_read(A_DATA, v); chk("R10 rx at new div", v, 32'h9C);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule